// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block picks the local interrupt that a hart should service next. Each cycle it forms the candidate set from the pending and enable vectors. It sorts every candidate into one of three delegation tiers: kept at machine level, handed to the host supervisor, or handed further to the guest supervisor. Each tier has its own gating rule, which depends on the current privilege, the virtualization flag and the two global interrupt-enable bits.

From the candidates that pass their tier's rule, the block selects the one with the lowest bit index. It presents that choice one clock later as a valid flag and a cause number. The trap entry logic uses these outputs to decide whether to redirect the hart and with which cause. Setting pending bits and performing the trap itself are handled elsewhere.

Top module: `irq_delegate_select`

## Requirements
- R1: A bit can only be selected when it is set in both `pend_i` and `enab_i`; a bit that is set in only one of the two is never reported.
- R2: A candidate whose `sdeleg_i` bit is 0 belongs to the machine tier. It qualifies when privilege is not machine (3), or when privilege is machine and `mie_i` is 1.
- R3: A candidate with `sdeleg_i`=1 and `gdeleg_i`=0 belongs to the host-supervisor tier. It qualifies when `virt_i` is 1 or the supervisor global enable holds.
- R4: A candidate with `sdeleg_i`=1 and `gdeleg_i`=1 belongs to the guest tier. It qualifies only when `virt_i` is 1 and the supervisor global enable holds.
- R5: The supervisor global enable holds when privilege is user (0), or when privilege is supervisor (1) and `sie_i` is 1. It never holds at machine privilege (3).
- R6: The privilege code 2 behaves exactly as user (0).
- R7: When several candidates qualify, the reported cause is the smallest qualifying bit index.
- R8: When no candidate qualifies, `take_o` is 0 and `cause_o` is 0.
- R9: The outputs change on the rising clock edge that follows the inputs. They reflect the inputs present at that edge and hold steady between edges.
- R10: While `rst_n` is low, `take_o` is 0 and `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | W | Pending interrupt bits |
| enab_i | input | W | Per-interrupt enable bits |
| sdeleg_i | input | W | 1 = interrupt delegated to supervisor |
| gdeleg_i | input | W | 1 = supervisor-delegated interrupt passed on to the guest |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 treated as user, 3 machine |
| virt_i | input | 1 | Hart is running virtualized |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt qualifies (registered) |
| cause_o | output | $clog2(W) | Bit index of the selected interrupt (registered) |

## Verification
The tier gating and the lowest-index priority act in the same cycle, and a fault in either one can hide behind the other. The bench provokes this with vectors where a low-index candidate sits in a tier that is blocked while a higher-index candidate in an open tier qualifies. The correct result is then the higher index, and the blocked bit must not be taken. Random vectors mix all three tiers across every privilege and virtualization combination. Each registered output is compared against a bench model, computed per bit from the requirements, on the cycle after the inputs were applied.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_SUP  = 2'd1,
    LVL_RSV  = 2'd2,
    LVL_MACH = 2'd3
  } lvl_e;

  typedef struct packed {
    logic mach_on;
    logic sup_on;
    logic virt;
  } gate_t;
endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       mie_i,
  input  logic       sie_i,
  output gate_t      gate_o
);
  lvl_e lvl;

  always_comb begin
    // code 2 folds onto user
    if (priv_i == 2'd2) lvl = LVL_USER;
    else                lvl = lvl_e'(priv_i);
  end

  always_comb begin
    gate_o.mach_on = (lvl != LVL_MACH) || mie_i;
    gate_o.sup_on  = (lvl == LVL_USER) || ((lvl == LVL_SUP) && sie_i);
    gate_o.virt    = virt_i;
  end
endmodule

// File: rtl/irq_tier_mask.sv
module irq_tier_mask
  import irq_sel_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] enab_i,
  input  logic [W-1:0] sdeleg_i,
  input  logic [W-1:0] gdeleg_i,
  input  gate_t        gate_i,
  output logic [W-1:0] qual_o
);
  logic host_open;
  logic guest_open;

  assign host_open  = gate_i.virt || gate_i.sup_on;
  assign guest_open = gate_i.virt && gate_i.sup_on;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic cand;
    logic tier_open;
    assign cand = pend_i[b] & enab_i[b];
    always_comb begin
      unique case ({sdeleg_i[b], gdeleg_i[b]})
        2'b10:   tier_open = host_open;
        2'b11:   tier_open = guest_open;
        default: tier_open = gate_i.mach_on;
      endcase
    end
    assign qual_o[b] = cand & tier_open;
  end
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int unsigned W  = 64,
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [CW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = CW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_delegate_select.sv
module irq_delegate_select
  import irq_sel_pkg::*;
#(
  parameter int unsigned W  = 64,
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pend_i,
  input  logic [W-1:0]  enab_i,
  input  logic [W-1:0]  sdeleg_i,
  input  logic [W-1:0]  gdeleg_i,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic          mie_i,
  input  logic          sie_i,
  output logic          take_o,
  output logic [CW-1:0] cause_o
);
  gate_t         gate_w;
  logic [W-1:0]  qual_w;
  logic          any_w;
  logic [CW-1:0] idx_w;

  logic          take_d, take_q;
  logic [CW-1:0] cause_d, cause_q;
  logic          upd_en;

  irq_level_gate u_gate (
    .priv_i (priv_i),
    .virt_i (virt_i),
    .mie_i  (mie_i),
    .sie_i  (sie_i),
    .gate_o (gate_w)
  );

  irq_tier_mask #(.W(W)) u_tier (
    .pend_i   (pend_i),
    .enab_i   (enab_i),
    .sdeleg_i (sdeleg_i),
    .gdeleg_i (gdeleg_i),
    .gate_i   (gate_w),
    .qual_o   (qual_w)
  );

  irq_low_pick #(.W(W)) u_pick (
    .vec_i (qual_w),
    .any_o (any_w),
    .idx_o (idx_w)
  );

  always_comb begin
    take_d  = any_w;
    cause_d = any_w ? idx_w : '0;
    upd_en  = (take_d != take_q) || (cause_d != cause_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      cause_q <= '0;
    end else if (upd_en) begin
      take_q  <= take_d;
      cause_q <= cause_d;
    end
  end

  assign take_o  = take_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/irq_delegate_select_chk.sv
module irq_delegate_select_chk #(
  parameter int unsigned W  = 64,
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  pend_i,
  input logic [W-1:0]  enab_i,
  input logic [W-1:0]  sdeleg_i,
  input logic [W-1:0]  gdeleg_i,
  input logic [1:0]    priv_i,
  input logic          virt_i,
  input logic          mie_i,
  input logic [W-1:0]  qual_w,
  input logic          take_o,
  input logic [CW-1:0] cause_o
);
  function automatic logic bit_at(logic [W-1:0] v, logic [CW-1:0] i);
    return v[i];
  endfunction

  function automatic logic below_clear(logic [W-1:0] v, logic [CW-1:0] i);
    logic [W-1:0] m;
    m = ({{(W-1){1'b0}}, 1'b1} << i) - 1'b1;
    return (v & m) == '0;
  endfunction

  // R8
  idle_cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> cause_o == '0);

  // R8
  idle_means_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(qual_w) == '0 |-> !take_o);

  // R1
  cand_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> bit_at($past(pend_i) & $past(enab_i), cause_o));

  // R7
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> bit_at($past(qual_w), cause_o) && below_clear($past(qual_w), cause_o));

  // R2
  mach_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && $past(priv_i) == 2'd3 && !$past(mie_i) |-> bit_at($past(sdeleg_i), cause_o));

  // R4
  guest_needs_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && bit_at($past(sdeleg_i) & $past(gdeleg_i), cause_o) |-> $past(virt_i));
endmodule

bind irq_delegate_select irq_delegate_select_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pend_i   (pend_i),
  .enab_i   (enab_i),
  .sdeleg_i (sdeleg_i),
  .gdeleg_i (gdeleg_i),
  .priv_i   (priv_i),
  .virt_i   (virt_i),
  .mie_i    (mie_i),
  .qual_w   (qual_w),
  .take_o   (take_o),
  .cause_o  (cause_o)
);

// File: tb/test_irq_delegate_select.sv
`timescale 1ns/1ps
module test_irq_delegate_select;
  localparam int W  = 64;
  localparam int CW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  pend, enab, sdel, gdel;
  logic [1:0]    priv;
  logic          virt, mie, sie;
  logic          take;
  logic [CW-1:0] cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_delegate_select #(.W(W)) i_irq_delegate_select (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab),
    .sdeleg_i(sdel), .gdeleg_i(gdel), .priv_i(priv), .virt_i(virt),
    .mie_i(mie), .sie_i(sie), .take_o(take), .cause_o(cause)
  );

  // model from the requirements
  function automatic void model(output logic t, output logic [CW-1:0] c);
    logic mon, son, ok;
    int p;
    p   = (priv == 2'd2) ? 0 : int'(priv);           // R6
    mon = (p != 3) || mie;                             // R2
    son = (p == 0) || (p == 1 && sie);                 // R5
    t = 1'b0; c = '0;
    for (int b = 0; b < W; b++) begin
      if (!sdel[b])      ok = mon;                     // R2
      else if (!gdel[b]) ok = virt || son;             // R3
      else               ok = virt && son;             // R4
      if (pend[b] && enab[b] && ok && !t) begin        // R1, R7
        t = 1'b1; c = CW'(b);
      end
    end
  endfunction

  task automatic chk(string req, logic et, logic [CW-1:0] ec);
    checks++;
    if (take !== et || cause !== ec) begin
      fails++;
      $display("FAIL %s take=%0b cause=%0d expected take=%0b cause=%0d", req, take, cause, et, ec);
    end
  endtask

  task automatic apply_chk(string req);
    logic et; logic [CW-1:0] ec;
    model(et, ec);
    @(negedge clk);
    chk(req, et, ec);
  endtask

  task automatic set_in(logic [W-1:0] p, logic [W-1:0] e, logic [W-1:0] s, logic [W-1:0] g,
                        logic [1:0] pr, logic v, logic m, logic si);
    pend = p; enab = e; sdel = s; gdel = g; priv = pr; virt = v; mie = m; sie = si;
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    rst_n = 1'b0;
    set_in('1, '1, '0, '0, 2'd0, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10 reset", 1'b0, '0);
    rst_n = 1'b1;

    // R1: pending without enable, enable without pending
    set_in(64'h0000_0000_0000_00F0, 64'h0000_0000_0000_000F, '0, '0, 2'd0, 0, 0, 0);
    apply_chk("R1 disjoint");
    // R8: nothing at all
    set_in('0, '1, '0, '0, 2'd3, 0, 1, 1);
    apply_chk("R8 none");
    // R2: machine tier at M without mie is blocked
    set_in(64'h100, '1, '0, '0, 2'd3, 0, 0, 0);
    apply_chk("R2 M blocked");
    set_in(64'h100, '1, '0, '0, 2'd3, 0, 1, 0);
    apply_chk("R2 M open");
    set_in(64'h100, '1, '0, '0, 2'd1, 0, 0, 0);
    apply_chk("R2 below M");
    // R5: supervisor tier at S with/without sie, at M never
    set_in(64'h20, '1, 64'h20, '0, 2'd1, 0, 1, 0);
    apply_chk("R5 S no sie");
    set_in(64'h20, '1, 64'h20, '0, 2'd1, 0, 1, 1);
    apply_chk("R5 S sie");
    set_in(64'h20, '1, 64'h20, '0, 2'd3, 0, 1, 1);
    apply_chk("R5 M never");
    // R3: host tier opened by virt alone
    set_in(64'h20, '1, 64'h20, '0, 2'd3, 1, 0, 0);
    apply_chk("R3 virt opens host");
    // R4: guest tier needs virt and sup enable
    set_in(64'h40, '1, 64'h40, 64'h40, 2'd0, 0, 0, 0);
    apply_chk("R4 no virt");
    set_in(64'h40, '1, 64'h40, 64'h40, 2'd0, 1, 0, 0);
    apply_chk("R4 virt user");
    set_in(64'h40, '1, 64'h40, 64'h40, 2'd1, 1, 0, 0);
    apply_chk("R4 virt S no sie");
    // R6: code 2 behaves as user
    set_in(64'h40, '1, 64'h40, 64'h40, 2'd2, 1, 0, 0);
    apply_chk("R6 code2 guest");
    set_in(64'h100, '1, '0, '0, 2'd2, 0, 0, 0);
    apply_chk("R6 code2 machine");
    // R7: blocked low bit, open high bit; then both open
    set_in(64'h8000_0000_0000_0002, '1, 64'h2, 64'h2, 2'd3, 0, 1, 1);
    apply_chk("R7 skip blocked low");
    set_in(64'h8000_0000_0000_0006, '1, 64'h6, 64'h2, 2'd0, 1, 0, 0);
    apply_chk("R7 lowest of many");
    set_in(64'h8000_0000_0000_0000, '1, '0, '0, 2'd0, 0, 0, 0);
    apply_chk("R7 top bit");
    set_in(64'h1, '1, '0, '0, 2'd0, 0, 0, 0);
    apply_chk("R7 bit zero");

    // R9: outputs hold until the next edge
    begin
      logic et; logic [CW-1:0] ec;
      set_in(64'h10, '1, '0, '0, 2'd0, 0, 0, 0);
      @(negedge clk);
      set_in(64'h400, '1, '0, '0, 2'd0, 0, 0, 0);
      #1 chk("R9 holds before edge", 1'b1, CW'(4));
      model(et, ec);
      @(negedge clk);
      chk("R9 after edge", et, ec);
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      set_in(rnd64() & rnd64() & rnd64(), rnd64() | rnd64(), rnd64(), rnd64(),
             2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
      apply_chk("R7 random");
    end

    // R10: reset mid-run
    set_in('1, '1, '0, '0, 2'd0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R10 async clear", 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule